// File: doc/BRIEF.md
# Scoreboard Issue Control Unit

This block is the central hazard bookkeeper for a small set of functional units that share one register file. Decoded instructions arrive in program order over a valid/ready handshake. Each names a target unit, one destination register and two source registers (an instruction with fewer sources repeats one). The block accepts an instruction when its target unit is idle and no unfinished instruction still owes a result to the same destination. It then tells each unit when it may read its operands and when it may put its result back into the register file.

Every register has only one storage ___location, so nothing is renamed. A register that an earlier instruction has yet to write holds back the operand read of later readers. A unit that has finished computing holds back its own write while any earlier instruction still has to read the old value. Neither case stops other units. A second write to a register that is already awaiting a write is the one case that blocks the whole input stream, and it lasts until the first write lands. Exceptions are not precise and no state is ever rolled back.

A unit reports the end of its computation with a one-cycle completion strobe. It receives three one-hot style strobes: issue, operand read grant and result write grant.

Top module: `sb_issue_ctrl`

## Requirements
- R1: After reset every unit is idle and no register has a write pending. `in_ready` is high for any in-range unit, and `issue_o`, `rd_gnt_o` and `wr_gnt_o` are all zero.
- R2: An instruction is taken in a cycle where `in_valid` and `in_ready` are both high. In that same cycle `issue_o` has exactly bit `in_unit` set. In every other cycle `issue_o` is zero.
- R3: `in_ready` is low while the unit selected by `in_unit` holds an instruction. A unit holds an instruction from the clock edge where it is issued until the clock edge where its write grant is given.
- R4: `in_ready` is low while `in_dst` is the destination of any accepted instruction whose write grant has not yet been given. This holds whichever unit `in_unit` selects.
- R5: `rd_gnt_o[u]` is high only when every source of the instruction in unit u is either free of pending writes at issue or has seen its producer's write grant. A source whose producer was granted in cycle n counts as available from cycle n+1. An instruction with no pending producers is granted in the cycle after its issue.
- R6: Each issued instruction receives exactly one single-cycle `rd_gnt_o` pulse, never in its own issue cycle.
- R7: A `fu_done[u]` strobe moves unit u to write-wait only when unit u has already had its read grant and is computing. Otherwise it is ignored. `wr_gnt_o[u]` can be high at the earliest in the cycle after the accepted strobe.
- R8: A unit in write-wait whose destination equals a source that another unit has not yet read, although that source is already available, gets no `wr_gnt_o`. Its grant comes in the first cycle after no such reader remains.
- R9: In the cycle after `wr_gnt_o[u]`, unit u is idle again and its destination register is no longer pending, so a new instruction for that unit and register can be accepted then.
- R10: If an instruction is accepted in the same cycle that the producer of one of its sources gets its write grant, that source counts as available at once. The new instruction is read-granted in the next cycle if its other source is also available.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present at the input |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| in_unit | input | UNIT_W | Index of the functional unit the instruction needs |
| in_dst | input | REG_W | Destination register |
| in_src1 | input | REG_W | First source register |
| in_src2 | input | REG_W | Second source register |
| fu_done | input | NUM_FU | Per-unit completion strobe |
| issue_o | output | NUM_FU | Per-unit issue strobe |
| rd_gnt_o | output | NUM_FU | Per-unit operand read grant |
| wr_gnt_o | output | NUM_FU | Per-unit result write grant |

## Verification
The hardest state to reach is a held-off write. One unit must have finished while a reader of its destination is ready on that operand but still unread. A reader reads in the very next cycle once both operands are available, so the stimulus has to block it on its other source behind a slow producer, and only then complete the writer. The bench builds exactly this chain directed, together with a completion strobe sent to a unit that is still waiting to read. It also issues a consumer in the very cycle its producer writes back, and then runs long random streams over a few registers to pile up every hazard at once. A behavioural model checks all outputs on every cycle.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_RDWAIT = 2'd1,
    PH_EXEC   = 2'd2,
    PH_WBWAIT = 2'd3
  } fu_phase_e;

  // Units are tagged 1..N; tag 0 means "no producer". Up to 64 units supported.
  function automatic logic writer_active(input int unsigned tag, input logic [63:0] wvec);
    if (tag == 0 || tag > 64) return 1'b0;
    return wvec[tag-1];
  endfunction

  // A pending (available, unread) source equal to a write target blocks that write.
  function automatic logic war_hazard(input logic pend, input logic [31:0] src,
                                      input logic [31:0] dst);
    return pend && (src == dst);
  endfunction

endpackage

// File: rtl/sb_reg_status.sv
`timescale 1ns/1ps
module sb_reg_status
  import sb_pkg::*;
#(
  parameter int NUM_FU   = 4,
  parameter int NUM_REGS = 16,
  localparam int REG_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int TAG_W   = $clog2(NUM_FU + 1)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               set_en,
  input  logic [REG_W-1:0]                   set_reg,
  input  logic [TAG_W-1:0]                   set_tag,
  input  logic [NUM_FU-1:0]                  wr_gnt,
  output logic [NUM_REGS-1:0][TAG_W-1:0]     tag_o,
  output logic [NUM_REGS-1:0]                pending_o
);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [TAG_W-1:0] owner_q;
    logic             release_w;

    assign release_w = writer_active(32'(owner_q), 64'(wr_gnt));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        owner_q <= '0;
      end else if (set_en && (set_reg == REG_W'(r))) begin
        owner_q <= set_tag;
      end else if (release_w) begin
        owner_q <= '0;
      end
    end

    assign tag_o[r]     = owner_q;
    assign pending_o[r] = (owner_q != '0);
  end

endmodule

// File: rtl/sb_fu_slot.sv
`timescale 1ns/1ps
module sb_fu_slot
  import sb_pkg::*;
#(
  parameter int NUM_FU   = 4,
  parameter int NUM_REGS = 16,
  parameter int UNIT_ID  = 0,
  localparam int REG_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int TAG_W   = $clog2(NUM_FU + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [REG_W-1:0]  dst_i,
  input  logic [REG_W-1:0]  src1_i,
  input  logic [REG_W-1:0]  src2_i,
  input  logic [TAG_W-1:0]  tag1_i,
  input  logic [TAG_W-1:0]  tag2_i,
  input  logic              done_i,
  input  logic [NUM_FU-1:0] wr_gnt_all_i,
  output logic              busy_o,
  output logic              rd_gnt_o,
  output logic              wbwait_o,
  output logic [REG_W-1:0]  dst_o,
  output logic [REG_W-1:0]  src1_o,
  output logic [REG_W-1:0]  src2_o,
  output logic              pend1_o,
  output logic              pend2_o
);

  fu_phase_e        ph_q;
  logic [REG_W-1:0] dst_q, s1_q, s2_q;
  logic [TAG_W-1:0] t1_q, t2_q;
  logic             r1_q, r2_q;
  logic             in_rdwait, wake1, wake2;

  assign in_rdwait = (ph_q == PH_RDWAIT);
  assign wake1     = in_rdwait && !r1_q && writer_active(32'(t1_q), 64'(wr_gnt_all_i));
  assign wake2     = in_rdwait && !r2_q && writer_active(32'(t2_q), 64'(wr_gnt_all_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      dst_q <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
      t1_q  <= '0;
      t2_q  <= '0;
      r1_q  <= 1'b0;
      r2_q  <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (issue_i) begin
          ph_q  <= PH_RDWAIT;
          dst_q <= dst_i;
          s1_q  <= src1_i;
          s2_q  <= src2_i;
          t1_q  <= tag1_i;
          t2_q  <= tag2_i;
          r1_q  <= (tag1_i == '0);
          r2_q  <= (tag2_i == '0);
        end
        PH_RDWAIT: begin
          if (rd_gnt_o) ph_q <= PH_EXEC;
          if (wake1)    r1_q <= 1'b1;
          if (wake2)    r2_q <= 1'b1;
        end
        PH_EXEC:   if (done_i) ph_q <= PH_WBWAIT;
        PH_WBWAIT: if (wr_gnt_all_i[UNIT_ID]) ph_q <= PH_IDLE;
        default:   ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o   = (ph_q != PH_IDLE);
  assign rd_gnt_o = in_rdwait && r1_q && r2_q;
  assign wbwait_o = (ph_q == PH_WBWAIT);
  assign dst_o    = dst_q;
  assign src1_o   = s1_q;
  assign src2_o   = s2_q;
  assign pend1_o  = in_rdwait && r1_q;
  assign pend2_o  = in_rdwait && r2_q;

endmodule

// File: rtl/sb_war_check.sv
`timescale 1ns/1ps
module sb_war_check
  import sb_pkg::*;
#(
  parameter int NUM_FU   = 4,
  parameter int NUM_REGS = 16,
  localparam int REG_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [NUM_FU-1:0] wbwait_i,
  input  logic [REG_W-1:0]  dst_i  [NUM_FU],
  input  logic [REG_W-1:0]  src1_i [NUM_FU],
  input  logic [REG_W-1:0]  src2_i [NUM_FU],
  input  logic [NUM_FU-1:0] pend1_i,
  input  logic [NUM_FU-1:0] pend2_i,
  output logic [NUM_FU-1:0] wr_gnt_o
);

  logic [NUM_FU-1:0] blocked;

  always_comb begin
    blocked = '0;
    for (int u = 0; u < NUM_FU; u++) begin
      for (int f = 0; f < NUM_FU; f++) begin
        if (f != u) begin
          blocked[u] = blocked[u]
                     | war_hazard(pend1_i[f], 32'(src1_i[f]), 32'(dst_i[u]))
                     | war_hazard(pend2_i[f], 32'(src2_i[f]), 32'(dst_i[u]));
        end
      end
    end
  end

  assign wr_gnt_o = wbwait_i & ~blocked;

endmodule

// File: rtl/sb_issue_ctrl.sv
`timescale 1ns/1ps
module sb_issue_ctrl
  import sb_pkg::*;
#(
  parameter int NUM_FU   = 4,
  parameter int NUM_REGS = 16,
  localparam int UNIT_W  = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
  localparam int REG_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int TAG_W   = $clog2(NUM_FU + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [UNIT_W-1:0] in_unit,
  input  logic [REG_W-1:0]  in_dst,
  input  logic [REG_W-1:0]  in_src1,
  input  logic [REG_W-1:0]  in_src2,
  input  logic [NUM_FU-1:0] fu_done,
  output logic [NUM_FU-1:0] issue_o,
  output logic [NUM_FU-1:0] rd_gnt_o,
  output logic [NUM_FU-1:0] wr_gnt_o
);

  // Named internal events (also observed by the bound checker)
  logic                          unit_ok, unit_free, dst_clear, fire;
  logic [NUM_REGS-1:0][TAG_W-1:0] reg_tag;
  logic [NUM_REGS-1:0]           reg_pending;
  logic [TAG_W-1:0]              raw1, raw2, tag1, tag2, new_tag;
  logic [NUM_FU-1:0]             slot_busy, slot_wbwait, slot_pend1, slot_pend2;
  logic [REG_W-1:0]              slot_dst  [NUM_FU];
  logic [REG_W-1:0]              slot_src1 [NUM_FU];
  logic [REG_W-1:0]              slot_src2 [NUM_FU];

  if (NUM_FU == (1 << UNIT_W)) begin : g_unit_full
    assign unit_ok = 1'b1;
  end else begin : g_unit_range
    assign unit_ok = (32'(in_unit) < NUM_FU);
  end

  assign unit_free = unit_ok && !slot_busy[in_unit];
  assign dst_clear = !reg_pending[in_dst];
  assign in_ready  = unit_free && dst_clear;
  assign fire      = in_valid && in_ready;
  assign new_tag   = TAG_W'(in_unit) + TAG_W'(1);

  // A producer writing back in the issue cycle is already resolved.
  assign raw1 = reg_tag[in_src1];
  assign raw2 = reg_tag[in_src2];
  assign tag1 = writer_active(32'(raw1), 64'(wr_gnt_o)) ? '0 : raw1;
  assign tag2 = writer_active(32'(raw2), 64'(wr_gnt_o)) ? '0 : raw2;

  sb_reg_status #(.NUM_FU(NUM_FU), .NUM_REGS(NUM_REGS)) u_regstat (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (fire),
    .set_reg   (in_dst),
    .set_tag   (new_tag),
    .wr_gnt    (wr_gnt_o),
    .tag_o     (reg_tag),
    .pending_o (reg_pending)
  );

  for (genvar u = 0; u < NUM_FU; u++) begin : g_slot
    assign issue_o[u] = fire && (32'(in_unit) == u);

    sb_fu_slot #(.NUM_FU(NUM_FU), .NUM_REGS(NUM_REGS), .UNIT_ID(u)) u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .issue_i      (issue_o[u]),
      .dst_i        (in_dst),
      .src1_i       (in_src1),
      .src2_i       (in_src2),
      .tag1_i       (tag1),
      .tag2_i       (tag2),
      .done_i       (fu_done[u]),
      .wr_gnt_all_i (wr_gnt_o),
      .busy_o       (slot_busy[u]),
      .rd_gnt_o     (rd_gnt_o[u]),
      .wbwait_o     (slot_wbwait[u]),
      .dst_o        (slot_dst[u]),
      .src1_o       (slot_src1[u]),
      .src2_o       (slot_src2[u]),
      .pend1_o      (slot_pend1[u]),
      .pend2_o      (slot_pend2[u])
    );
  end

  sb_war_check #(.NUM_FU(NUM_FU), .NUM_REGS(NUM_REGS)) u_war (
    .wbwait_i (slot_wbwait),
    .dst_i    (slot_dst),
    .src1_i   (slot_src1),
    .src2_i   (slot_src2),
    .pend1_i  (slot_pend1),
    .pend2_i  (slot_pend2),
    .wr_gnt_o (wr_gnt_o)
  );

endmodule

// File: rtl/sb_issue_ctrl_chk.sv
`timescale 1ns/1ps
module sb_issue_ctrl_chk #(
  parameter int NUM_FU   = 4,
  parameter int NUM_REGS = 16,
  localparam int UNIT_W  = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
  localparam int REG_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [UNIT_W-1:0] in_unit,
  input logic [REG_W-1:0]  in_dst,
  input logic [NUM_FU-1:0] issue_o,
  input logic [NUM_FU-1:0] rd_gnt_o,
  input logic [NUM_FU-1:0] wr_gnt_o,
  input logic [NUM_FU-1:0] slot_busy,
  input logic [NUM_REGS-1:0] reg_pending
);

  a_r2_issue_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_o));

  a_r2_issue_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o != '0) |-> (in_valid && in_ready));

  a_r3_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    slot_busy[in_unit] |-> !in_ready);

  a_r4_waw_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    reg_pending[in_dst] |-> !in_ready);

  a_r6_no_read_at_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_gnt_o & issue_o) == '0);

  a_r6_read_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_gnt_o != '0) |=> ((rd_gnt_o & $past(rd_gnt_o)) == '0));

  a_r7_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_gnt_o & ~slot_busy) == '0);

  a_r9_write_frees_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_gnt_o != '0) |=> ((slot_busy & $past(wr_gnt_o)) == '0));

endmodule

bind sb_issue_ctrl sb_issue_ctrl_chk #(.NUM_FU(NUM_FU), .NUM_REGS(NUM_REGS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_unit     (in_unit),
  .in_dst      (in_dst),
  .issue_o     (issue_o),
  .rd_gnt_o    (rd_gnt_o),
  .wr_gnt_o    (wr_gnt_o),
  .slot_busy   (slot_busy),
  .reg_pending (reg_pending)
);

// File: tb/sb_issue_ctrl_tb.sv
`timescale 1ns/1ps
module sb_issue_ctrl_tb;

  localparam int NFU  = 4;
  localparam int NREG = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_unit = '0;
  logic [3:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [NFU-1:0] fu_done = '0;
  logic [NFU-1:0] issue_o, rd_gnt_o, wr_gnt_o;

  always #2 clk = ~clk;  // 250 MHz

  sb_issue_ctrl #(.NUM_FU(NFU), .NUM_REGS(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_unit(in_unit), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .fu_done(fu_done), .issue_o(issue_o), .rd_gnt_o(rd_gnt_o), .wr_gnt_o(wr_gnt_o)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  // Reference model: phase 0 idle, 1 wait read, 2 compute, 3 wait write
  int m_ph  [NFU];
  int m_dst [NFU];
  int m_src [NFU][2];
  int m_wt  [NFU][2];   // producer unit, -1 when available
  int m_own [NREG];     // pending writer unit, -1 when none

  bit       exp_rdy;
  bit [NFU-1:0] exp_iss, exp_rd, exp_wr;
  bit [NFU-1:0] obs_iss, obs_rd, obs_wr;
  bit       obs_rdy;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_eval(input int v, input int un, input int d);
    exp_rdy = (m_ph[un] == 0) && (m_own[d] < 0);
    exp_iss = '0;
    if (v != 0 && exp_rdy) exp_iss[un] = 1'b1;
    for (int u = 0; u < NFU; u++) begin
      exp_rd[u] = (m_ph[u] == 1) && (m_wt[u][0] < 0) && (m_wt[u][1] < 0);
      exp_wr[u] = (m_ph[u] == 3);
      for (int f = 0; f < NFU; f++) begin
        if (f != u && m_ph[f] == 1) begin
          for (int k = 0; k < 2; k++)
            if (m_src[f][k] == m_dst[u] && m_wt[f][k] < 0) exp_wr[u] = 1'b0;
        end
      end
    end
  endfunction

  function automatic void model_update(input int un, input int d, input int s1, input int s2,
                                       input bit [NFU-1:0] done);
    int old_ph [NFU];
    int nt [2];
    int srcs [2];
    srcs[0] = s1; srcs[1] = s2;
    for (int k = 0; k < 2; k++) begin
      int o = m_own[srcs[k]];
      nt[k] = (o >= 0 && !exp_wr[o]) ? o : -1;
    end
    for (int u = 0; u < NFU; u++) old_ph[u] = m_ph[u];
    for (int u = 0; u < NFU; u++) begin
      if (exp_wr[u]) begin
        m_ph[u] = 0;
        if (m_own[m_dst[u]] == u) m_own[m_dst[u]] = -1;
      end
      if (exp_rd[u]) m_ph[u] = 2;
      if (old_ph[u] == 2 && done[u]) m_ph[u] = 3;
      if (old_ph[u] == 1) begin
        for (int k = 0; k < 2; k++)
          if (m_wt[u][k] >= 0 && exp_wr[m_wt[u][k]]) m_wt[u][k] = -1;
      end
    end
    if (exp_iss != '0) begin
      m_ph[un] = 1;
      m_dst[un] = d;
      m_src[un][0] = s1; m_src[un][1] = s2;
      m_wt[un][0] = nt[0]; m_wt[un][1] = nt[1];
      m_own[d] = un;
    end
  endfunction

  task automatic step(input bit v, input int un, input int d, input int s1, input int s2,
                      input bit [NFU-1:0] done);
    string rq;
    @(negedge clk);
    in_valid = v; in_unit = 2'(un); in_dst = 4'(d); in_src1 = 4'(s1); in_src2 = 4'(s2);
    fu_done = done;
    #1;
    model_eval(v, un, d);
    obs_rdy = in_ready; obs_iss = issue_o; obs_rd = rd_gnt_o; obs_wr = wr_gnt_o;
    rq = (m_own[d] >= 0) ? "R4 ready" : (m_ph[un] != 0) ? "R3 ready" : "R9 ready";
    chk(obs_rdy == exp_rdy, rq, obs_rdy, exp_rdy);
    chk(obs_iss == exp_iss, "R2 issue", obs_iss, exp_iss);
    chk(obs_rd == exp_rd, "R5 R6 R10 read grant", obs_rd, exp_rd);
    chk(obs_wr == exp_wr, "R7 R8 write grant", obs_wr, exp_wr);
    @(posedge clk);
    model_update(un, d, s1, s2, done);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    for (int u = 0; u < NFU; u++) begin
      m_ph[u] = 0; m_dst[u] = 0;
      for (int k = 0; k < 2; k++) begin m_src[u][k] = 0; m_wt[u][k] = -1; end
    end
    for (int r = 0; r < NREG; r++) m_own[r] = -1;

    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
    chk(issue_o == '0, "R1 issue", issue_o, 0);
    chk(rd_gnt_o == '0, "R1 read grant", rd_gnt_o, 0);
    chk(wr_gnt_o == '0, "R1 write grant", wr_gnt_o, 0);

    // Hazard chain: RAW, WAW, structural, done ignored, same-cycle wakeup
    step(1, 0, 1, 2, 3, 4'b0000);
    chk(obs_iss == 4'b0001, "R2 issue unit0", obs_iss, 1);
    step(1, 0, 5, 2, 3, 4'b0000);
    chk(obs_rdy == 0, "R3 busy unit0", obs_rdy, 0);
    chk(obs_rd[0] == 1, "R5 read next cycle", obs_rd[0], 1);
    step(1, 1, 1, 4, 4, 4'b0000);
    chk(obs_rdy == 0, "R4 dst r1 pending", obs_rdy, 0);
    step(1, 2, 6, 1, 7, 4'b0000);
    step(0, 0, 0, 0, 0, 4'b0001);
    chk(obs_rd[2] == 0, "R5 consumer waits", obs_rd[2], 0);
    step(1, 3, 7, 1, 1, 4'b0000);
    chk(obs_wr[0] == 1, "R7 write after done", obs_wr[0], 1);
    step(1, 0, 1, 0, 0, 4'b0000);
    chk(obs_rd[2] == 1, "R5 read after producer write", obs_rd[2], 1);
    chk(obs_rd[3] == 1, "R10 same-cycle wakeup", obs_rd[3], 1);
    chk(obs_iss == 4'b0001, "R9 unit and register freed", obs_iss, 1);
    step(0, 0, 0, 0, 0, 4'b1101);
    step(0, 0, 0, 0, 0, 4'b0000);
    chk(obs_wr == 4'b1100, "R7 done ignored while waiting read", obs_wr, 4'hc);
    step(0, 0, 0, 0, 0, 4'b0001);
    step(0, 0, 0, 0, 0, 4'b0000);

    // WAR hold-off: reader of r9 stuck on r8, writer of r9 finishes early
    step(1, 0, 8, 0, 0, 4'b0000);
    step(1, 1, 11, 9, 8, 4'b0000);
    step(1, 2, 9, 10, 10, 4'b0000);
    step(0, 0, 0, 0, 0, 4'b0000);
    step(0, 0, 0, 0, 0, 4'b0100);
    step(0, 0, 0, 0, 0, 4'b0000);
    chk(obs_wr[2] == 0, "R8 write held by unread source", obs_wr[2], 0);
    step(0, 0, 0, 0, 0, 4'b0001);
    chk(obs_wr[2] == 0, "R8 write still held", obs_wr[2], 0);
    step(0, 0, 0, 0, 0, 4'b0000);
    chk(obs_wr == 4'b0001, "R8 producer writes, reader blocked", obs_wr, 1);
    step(0, 0, 0, 0, 0, 4'b0000);
    chk(obs_rd[1] == 1 && obs_wr[2] == 0, "R8 reader reads, writer waits", {obs_rd, obs_wr}, 8'h20);
    step(0, 0, 0, 0, 0, 4'b0000);
    chk(obs_wr[2] == 1, "R8 write released", obs_wr[2], 1);
    step(0, 0, 0, 0, 0, 4'b0010);
    step(0, 0, 0, 0, 0, 4'b0000);

    // Random streams over a small register window
    for (int i = 0; i < 6000; i++) begin
      bit [NFU-1:0] dn;
      for (int u = 0; u < NFU; u++) dn[u] = ($urandom_range(0, 2) == 0);
      step(($urandom_range(0, 1) == 1), $urandom_range(0, NFU-1), $urandom_range(0, 5),
           $urandom_range(0, 5), $urandom_range(0, 5), dn);
    end

    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule